// File: doc/BRIEF.md
# Horizontal Active-Window Generator with Start Adjustment

This block marks the active part of each digitised video line. A rising edge on the horizontal sync input marks the line reference. From that edge the block counts clock cycles and raises an active-window flag once the start point is reached. The start point depends on the line standard, either 525 or 625 lines. A 3-bit adjust code can move it earlier or later in whole pixel samples, and one sample lasts two clocks. The window always lasts 720 samples (1440 clocks), so when the start moves, the end moves with it.

While the window is open, a data-valid strobe pulses on the first clock of every sample, and a pixel index counts 0 to 719. Downstream capture logic uses the flag, the strobe and the index to pick pixels out of the sample stream. The line standard and the adjust code are captured only at the sync edge. Changing them in the middle of a line therefore takes effect on the next line.

The controller is a three-state machine:
- **ST_IDLE**: the state after reset and after a window closes. It waits for a sync edge.
- **ST_LEAD**: counts clocks from the sync edge up to the start point.
- **ST_ACTIVE**: the window is open.

Its transitions are:
- **T_SYNC**: any state goes to ST_LEAD on a sync rising edge.
- **T_OPEN**: ST_LEAD goes to ST_ACTIVE when the lead count reaches the start point.
- **T_CLOSE**: ST_ACTIVE goes to ST_IDLE after the last clock of sample 719.

Top module: `hwin_gen`

## Requirements
- R1: After reset, and until the first rising edge of `hsync_i`, `win_o`, `dv_o` and `pix_idx_o` are all 0. An asserted reset forces them to 0 at once.
- R2: Take edge 0 to be the first clock edge at which `hsync_i` is sampled high after being low. With adjust code 000, `win_o` first reads high after edge 244 when `std625_i`=0 (525 lines), or after edge 264 when `std625_i`=1 (625 lines).
- R3: Adjust codes 001, 010 and 011 delay the start by 2, 4 and 6 clocks (1, 2 and 3 samples).
- R4: Adjust codes 111, 110 and 101 advance the start by 2, 4 and 6 clocks (1, 2 and 3 samples).
- R5: Adjust code 100 is reserved and places the window exactly as code 000 does.
- R6: `win_o` stays high for exactly 1440 consecutive clocks, whatever the code and standard.
- R7: `dv_o` is high on the 1st, 3rd, 5th, ... clock of the window (720 pulses) and low on every other clock, inside and outside the window.
- R8: `pix_idx_o` is 0 on the first two window clocks and rises by 1 on each `dv_o` pulse, reaching 719. Outside the window it is 0.
- R9: `adj_code_i` and `std625_i` are captured at the sync edge. Changing them later in the line does not move that line's window, and the new values apply from the next sync edge.
- R10: A sync rising edge inside an open window closes it on the next clock and starts a new line reference. A sync held high counts as one edge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two cycles per pixel sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync; its rising edge is the line reference |
| std625_i | input | 1 | Line standard: 0 = 525 lines, 1 = 625 lines |
| adj_code_i | input | 3 | Start adjust code (delay 001/010/011, advance 111/110/101, 100 reserved) |
| win_o | output | 1 | Active-window flag |
| dv_o | output | 1 | Data-valid strobe, first clock of each sample inside the window |
| pix_idx_o | output | 10 | Pixel index within the window, 0 outside |

## Verification
The main function is exercised with one line per adjust code under the 525 standard, and with nominal, reserved, maximum-delay and maximum-advance codes under the 625 standard. Each line checks the first window clock, the window length, the strobe phase and the index ramp. Together these separate a swapped advance order, a reserved code treated as an advance, a wrong base offset, and an end that fails to follow the start. Directed lines then:
- change the code and standard mid-line, to show they are captured at the edge;
- re-trigger sync inside a window;
- assert reset in a window and then hold sync idle.

// File: rtl/hwin_pkg.sv
package hwin_pkg;

    // Largest shift, in samples, that the 3-bit adjust code can select
    localparam int MAX_STEP = 3;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_ACTIVE = 2'd2
    } hwin_state_e;

endpackage

// File: rtl/hwin_line_cfg.sv
// Finds the sync rising edge and captures the line configuration on it
module hwin_line_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_i,
    input  logic       std_i,
    input  logic [2:0] code_i,
    output logic       sync_rise_o,
    output logic       std_q_o,
    output logic [2:0] code_q_o
);

    logic hs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
        end else begin
            hs_q <= hsync_i;
        end
    end

    // Only the low-to-high transition counts; a wide pulse is one reference
    assign sync_rise_o = hsync_i & ~hs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            std_q_o  <= 1'b0;
            code_q_o <= 3'b000;
        end else if (sync_rise_o) begin
            std_q_o  <= std_i;
            code_q_o <= code_i;
        end
    end

endmodule

// File: rtl/hwin_start_calc.sv
// Turns the captured standard and adjust code into a start count in clocks
module hwin_start_calc #(
    parameter int NOM_525 = 244,
    parameter int NOM_625 = 264,
    parameter int CPS     = 2,
    parameter int LEAD_W  = 9
) (
    input  logic              std_i,
    input  logic [2:0]        code_i,
    output logic [LEAD_W-1:0] start_o
);

    logic [1:0] steps;
    logic       adv;
    int         base_i;
    int         shift_i;

    // Delay codes count up from 001; advance codes count down from 111
    always_comb begin
        unique case (code_i)
            3'b001:         begin steps = 2'd1; adv = 1'b0; end
            3'b010:         begin steps = 2'd2; adv = 1'b0; end
            3'b011:         begin steps = 2'd3; adv = 1'b0; end
            3'b111:         begin steps = 2'd1; adv = 1'b1; end
            3'b110:         begin steps = 2'd2; adv = 1'b1; end
            3'b101:         begin steps = 2'd3; adv = 1'b1; end
            3'b000, 3'b100: begin steps = 2'd0; adv = 1'b0; end
        endcase
    end

    always_comb begin
        base_i  = std_i ? NOM_625 : NOM_525;
        shift_i = int'(steps) * CPS;
        start_o = LEAD_W'(adv ? (base_i - shift_i) : (base_i + shift_i));
    end

endmodule

// File: rtl/hwin_smp_cnt.sv
// Sample phase and pixel counters, held at zero while the window is closed
module hwin_smp_cnt #(
    parameter int CPS     = 2,
    parameter int ACT_SMP = 720,
    parameter int PH_W    = 1,
    parameter int PIX_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic [PH_W-1:0]  ph_o,
    output logic [PIX_W-1:0] pix_o,
    output logic             last_o
);

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CPS - 1);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(ACT_SMP - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_o  <= '0;
            pix_o <= '0;
        end else if (!run_i) begin
            ph_o  <= '0;
            pix_o <= '0;
        end else if (ph_o == PH_LAST) begin
            ph_o  <= '0;
            pix_o <= (pix_o == PIX_LAST) ? '0 : pix_o + PIX_W'(1);
        end else begin
            ph_o  <= ph_o + PH_W'(1);
        end
    end

    assign last_o = run_i && (ph_o == PH_LAST) && (pix_o == PIX_LAST);

endmodule

// File: rtl/hwin_gen.sv
module hwin_gen
    import hwin_pkg::*;
#(
    parameter int CLK_PER_SMP = 2,
    parameter int ACT_SMP     = 720,
    parameter int NOM_525     = 244,
    parameter int NOM_625     = 264
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hsync_i,
    input  logic        std625_i,
    input  logic [2:0]  adj_code_i,
    output logic        win_o,
    output logic        dv_o,
    output logic [9:0]  pix_idx_o
);

    localparam int ACT_CLKS = ACT_SMP * CLK_PER_SMP;
    localparam int NOM_MAX  = (NOM_525 > NOM_625) ? NOM_525 : NOM_625;
    localparam int LEAD_W   = $clog2(NOM_MAX + MAX_STEP * CLK_PER_SMP + 1);
    localparam int PH_W     = (CLK_PER_SMP > 1) ? $clog2(CLK_PER_SMP) : 1;
    localparam int PIX_W    = 10;

    hwin_state_e       state_q;
    hwin_state_e       state_d;
    logic              sync_rise;
    logic              std_q;
    logic [2:0]        code_q;
    logic [LEAD_W-1:0] start_clk;
    logic [LEAD_W-1:0] lead_cnt;
    logic [PH_W-1:0]   ph;
    logic [PIX_W-1:0]  pix;
    logic              last_clk;

    hwin_line_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_i     (hsync_i),
        .std_i       (std625_i),
        .code_i      (adj_code_i),
        .sync_rise_o (sync_rise),
        .std_q_o     (std_q),
        .code_q_o    (code_q)
    );

    hwin_start_calc #(
        .NOM_525 (NOM_525),
        .NOM_625 (NOM_625),
        .CPS     (CLK_PER_SMP),
        .LEAD_W  (LEAD_W)
    ) u_start (
        .std_i   (std_q),
        .code_i  (code_q),
        .start_o (start_clk)
    );

    hwin_smp_cnt #(
        .CPS     (CLK_PER_SMP),
        .ACT_SMP (ACT_SMP),
        .PH_W    (PH_W),
        .PIX_W   (PIX_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_ACTIVE),
        .ph_o   (ph),
        .pix_o  (pix),
        .last_o (last_clk)
    );

    // Lead counter: clocks elapsed since the sync edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_cnt <= '0;
        end else if (sync_rise) begin
            lead_cnt <= '0;
        end else if (state_q == ST_LEAD) begin
            lead_cnt <= lead_cnt + LEAD_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_SYNC from any state, T_OPEN, T_CLOSE
    always_comb begin
        state_d = state_q;
        if (sync_rise) begin
            state_d = ST_LEAD;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_LEAD:   if (lead_cnt == start_clk - LEAD_W'(1)) state_d = ST_ACTIVE;
                ST_ACTIVE: if (last_clk) state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        win_o     = (state_q == ST_ACTIVE);
        dv_o      = win_o && (ph == '0);
        pix_idx_o = win_o ? pix : '0;
    end

endmodule

// File: rtl/hwin_gen_chk.sv
module hwin_gen_chk #(
    parameter int ACT_CLKS = 1440,
    parameter int PIX_W    = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync_i,
    input logic             win_o,
    input logic             dv_o,
    input logic [PIX_W-1:0] pix_idx_o
);

    localparam int RUN_W = $clog2(ACT_CLKS + 1);

    // Consecutive window clocks seen before the current one
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else begin
            run <= win_o ? run + RUN_W'(1) : '0;
        end
    end

    AST_WIN_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        win_o |-> run < RUN_W'(ACT_CLKS)); // R6

    AST_DV_INSIDE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        dv_o |-> win_o); // R7

    AST_DV_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        dv_o |=> !dv_o); // R7

    AST_WIN_OPENS_ON_DV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_o) |-> (dv_o && pix_idx_o == '0)); // R8

    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o && dv_o && $past(win_o)) |-> pix_idx_o == $past(pix_idx_o) + PIX_W'(1)); // R8

    AST_PIX_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !win_o |-> pix_idx_o == '0); // R8

    AST_SYNC_CLOSES_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_i) |=> !win_o); // R10

endmodule

bind hwin_gen hwin_gen_chk #(
    .ACT_CLKS (ACT_CLKS),
    .PIX_W    (PIX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_i   (hsync_i),
    .win_o     (win_o),
    .dv_o      (dv_o),
    .pix_idx_o (pix_idx_o)
);

// File: tb/sim_hwin_gen.sv
`timescale 1ns/1ps
module sim_hwin_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hsync;
    logic       std_sel;
    logic [2:0] adj;
    logic       win_o;
    logic       dv_o;
    logic [9:0] pix_idx_o;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    hwin_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_i    (hsync),
        .std625_i   (std_sel),
        .adj_code_i (adj),
        .win_o      (win_o),
        .dv_o       (dv_o),
        .pix_idx_o  (pix_idx_o)
    );

    // {std, code, expected first window clock}
    localparam logic [12:0] VEC [12] = '{
        {1'b0, 3'b000, 9'd244},
        {1'b0, 3'b001, 9'd246},
        {1'b0, 3'b010, 9'd248},
        {1'b0, 3'b011, 9'd250},
        {1'b0, 3'b111, 9'd242},
        {1'b0, 3'b110, 9'd240},
        {1'b0, 3'b101, 9'd238},
        {1'b0, 3'b100, 9'd244},
        {1'b1, 3'b000, 9'd264},
        {1'b1, 3'b011, 9'd270},
        {1'b1, 3'b101, 9'd258},
        {1'b1, 3'b100, 9'd264}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b000:                 return "R2";
            3'b100:                 return "R5";
            3'b001, 3'b010, 3'b011: return "R3";
            default:                return "R4";
        endcase
    endfunction

    task automatic start_line();
        @(negedge clk);
        hsync = 1'b1;
    endtask

    // Walks one line from the sync edge and checks window, strobe and index
    task automatic check_line(input int exp_s, input string tag, input int mid_k,
                              input logic [2:0] mid_code, input logic mid_std);
        int first_k = -1;
        int n_win   = 0;
        int n_dv    = 0;
        int bad_dv  = 0;
        int bad_pix = 0;
        for (int k = 0; k < 1800; k++) begin
            bit ew;
            @(negedge clk);
            ew = (k >= exp_s) && (k < exp_s + 1440);
            if (win_o) begin
                if (first_k < 0) first_k = k;
                n_win++;
            end
            if (dv_o) n_dv++;
            if (dv_o !== (ew && ((k - exp_s) % 2 == 0))) bad_dv++;
            if (int'(pix_idx_o) != (ew ? (k - exp_s) / 2 : 0)) bad_pix++;
            if (k == 127) hsync = 1'b0;
            if (k == mid_k) begin
                adj     = mid_code;
                std_sel = mid_std;
            end
        end
        chk(first_k == exp_s, tag, first_k, exp_s);
        chk(n_win == 1440, "R6", n_win, 1440);
        chk(n_dv == 720 && bad_dv == 0, "R7", n_dv + bad_dv * 10000, 720);
        chk(bad_pix == 0, "R8", bad_pix, 0);
    endtask

    task automatic run_all();
        int seen;
        // R1: reset state and no window without sync
        rst_n = 1'b0; hsync = 1'b0; adj = 3'b000; std_sel = 1'b0;
        repeat (4) @(negedge clk);
        chk(!win_o && !dv_o && pix_idx_o == 0, "R1", {win_o, dv_o}, 0);
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (win_o || dv_o || pix_idx_o != 0) seen++;
        end
        chk(seen == 0, "R1", seen, 0);

        // Table of standards and codes
        for (int v = 0; v < 12; v++) begin
            std_sel = VEC[v][12];
            adj     = VEC[v][11:9];
            start_line();
            check_line(int'(VEC[v][8:0]), tag_of(VEC[v][11:9]), -1, VEC[v][11:9], VEC[v][12]);
        end

        // R9: mid-line change does not move the current window, applies next line
        std_sel = 1'b0; adj = 3'b000;
        start_line();
        check_line(244, "R9", 100, 3'b011, 1'b1);
        start_line();
        check_line(270, "R9", -1, 3'b011, 1'b1);

        // R10: sync inside an open window restarts the line
        std_sel = 1'b0; adj = 3'b000;
        start_line();
        for (int k = 0; k <= 600; k++) begin
            @(negedge clk);
            if (k == 127) hsync = 1'b0;
        end
        chk(win_o == 1'b1 && int'(pix_idx_o) == 178, "R10", int'(pix_idx_o), 178);
        hsync = 1'b1; adj = 3'b011;
        check_line(250, "R10", -1, 3'b011, 1'b0);

        // R1: reset inside a window, then no window without sync
        std_sel = 1'b0; adj = 3'b000;
        start_line();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (k == 127) hsync = 1'b0;
        end
        chk(win_o == 1'b1, "R1", win_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!win_o && !dv_o && pix_idx_o == 0, "R1", {win_o, dv_o}, 0);
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (win_o) seen++;
        end
        chk(seen == 0, "R1", seen, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule